// File: doc/BRIEF.md
# Timer Compare Channel

This block is one compare channel for a 16-bit timer. A register bus of 8 bits loads the 16-bit compare value in two steps. A write to the upper byte only parks that byte in a temporary register, which a counter can also use for its own wide access. The following lower-byte write moves both bytes into a 16-bit staging register. That staging register feeds the active compare register either at once or on an update strobe from the counter, depending on the selected mode.

On every timer tick, an equality comparator checks the counter against the active value. A hit sets a sticky flag and gives a one-cycle match pulse to a waveform generator. It also acts on an output pin according to a 2-bit action code. The flag raises an interrupt request when enabled. It clears when the interrupt is acknowledged or when software writes a one to it. When the channel is built as the period source, its active value is offered to the counter as the top count.

Top module: `tcmp_channel`

## Requirements
- R1: After reset, the temporary byte, the staging and active values, the flag, the interrupt enable, the match pulse and the pin are all 0.
- R2: A bus write to address 1 (upper byte) loads only the temporary byte, which appears on `tmp_byte` after the edge. The active value is unchanged.
- R3: A bus write to address 0 (lower byte) loads the staging register with {temporary byte, written byte} in one edge. When `buf_mode` is 0, the active value takes the same word at that edge.
- R4: When `buf_mode` is 1, the active value keeps its old word until an edge with `upd_strobe` high, which copies the staging register into it.
- R5: At an edge where `tick` is 1 and `cnt` equals the active value, `match_pulse` is high for the one clock that follows. Equality while `tick` is 0 gives no pulse.
- R6: `cmp_flag` becomes 1 at that same edge, one timer clock after the equality is seen, and stays set until it is cleared.
- R7: `irq` is high exactly when the flag is set and the interrupt enable (bit 1 of address 2) is 1.
- R8: `irq_ack` clears the flag at the next edge. A new hit in the same cycle wins, and the flag stays 1.
- R9: A bus write to address 2 clears the flag if data bit 0 is 1 and leaves it alone if bit 0 is 0. Data bit 1 is loaded as the interrupt enable in both cases.
- R10: On a hit, `pin_mode` acts on the pin as follows: 00 detaches it (`pin_oe`=0, level held), 01 toggles it, 10 drives it to 0 and 11 drives it to 1. `pin_oe` is 1 for every mode except 00. Without a hit the level holds.
- R11: With `TOP_SRC`=1, `top_value` equals the active value. With `TOP_SRC`=0 it is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer clock enable |
| cnt | input | CNT_W | Counter value |
| upd_strobe | input | 1 | Counter TOP/BOTTOM update strobe |
| buf_mode | input | 1 | 1: staged update, 0: immediate update |
| pin_mode | input | 2 | Pin action code |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | 0 lower byte, 1 upper byte, 2 control |
| bus_wdata | input | BUS_W | Write data |
| irq_ack | input | 1 | Interrupt acknowledge |
| tmp_byte | output | CNT_W-BUS_W | Shared temporary upper byte |
| active_cmp | output | CNT_W | Active compare value |
| cmp_flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |
| match_pulse | output | 1 | One-cycle match strobe |
| pin_out | output | 1 | Pin level |
| pin_oe | output | 1 | Pin drive enable |
| top_value | output | CNT_W | Top count offered to the counter |

## Verification
The bench builds the channel with the default widths of 16 and 8 bits and `TOP_SRC`=1 as `u_dut`. It also builds a second copy with `TOP_SRC`=0 on the same inputs, so both variants of the top-value generate branch are checked. With these widths, the two-step byte load, staged versus immediate update, and every pin action can be checked with exact 16-bit words. Hits and flag races are forced through direct control of `cnt` and `tick`.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
   typedef enum logic [1:0] {
      PIN_OFF = 2'b00,
      PIN_TOG = 2'b01,
      PIN_CLR = 2'b10,
      PIN_SET = 2'b11
   } pin_act_e;

   localparam logic [1:0] ADDR_LO  = 2'd0;
   localparam logic [1:0] ADDR_HI  = 2'd1;
   localparam logic [1:0] ADDR_CTL = 2'd2;

   localparam int CTL_CLR_BIT = 0;
   localparam int CTL_IE_BIT  = 1;
endpackage

// File: rtl/tcmp_regif.sv
module tcmp_regif #(
   parameter int CNT_W = 16,
   parameter int BUS_W = 8,
   localparam int HI_W = CNT_W - BUS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic [1:0]       bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   input  logic             buf_mode,
   input  logic             upd_strobe,
   output logic [HI_W-1:0]  tmp_byte,
   output logic [CNT_W-1:0] active_val
);
   import tcmp_pkg::*;

   logic [CNT_W-1:0] stage_q;
   logic [CNT_W-1:0] new_word;
   logic             lo_we;
   logic             hi_we;

   assign lo_we    = bus_we && (bus_addr == ADDR_LO);
   assign hi_we    = bus_we && (bus_addr == ADDR_HI);
   assign new_word = {tmp_byte, bus_wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmp_byte <= '0;
      end else if (hi_we) begin
         tmp_byte <= bus_wdata[HI_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (lo_we) begin
         stage_q <= new_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_val <= '0;
      end else if (!buf_mode && lo_we) begin
         active_val <= new_word;
      end else if (buf_mode && upd_strobe) begin
         active_val <= stage_q;
      end
   end
endmodule

// File: rtl/tcmp_match.sv
module tcmp_match #(
   parameter int CNT_W = 16,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] active_val,
   input  logic             ctl_we,
   input  logic [BUS_W-1:0] ctl_data,
   input  logic             irq_ack,
   output logic             hit,
   output logic             match_pulse,
   output logic             flag,
   output logic             irq
);
   import tcmp_pkg::*;

   logic ie_q;

   assign hit = tick && (cnt == active_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_pulse <= 1'b0;
      end else begin
         match_pulse <= hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (hit) begin
         flag <= 1'b1;
      end else if (irq_ack || (ctl_we && ctl_data[CTL_CLR_BIT])) begin
         flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q <= 1'b0;
      end else if (ctl_we) begin
         ie_q <= ctl_data[CTL_IE_BIT];
      end
   end

   assign irq = flag && ie_q;
endmodule

// File: rtl/tcmp_pin.sv
module tcmp_pin (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  logic [1:0] pin_mode,
   output logic       pin_out,
   output logic       pin_oe
);
   import tcmp_pkg::*;

   pin_act_e act;
   logic     nxt;

   assign act = pin_act_e'(pin_mode);

   always_comb begin
      unique case (act)
         PIN_TOG: nxt = ~pin_out;
         PIN_CLR: nxt = 1'b0;
         PIN_SET: nxt = 1'b1;
         default: nxt = pin_out;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_out <= 1'b0;
      end else if (hit) begin
         pin_out <= nxt;
      end
   end

   assign pin_oe = (act != PIN_OFF);
endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel #(
   parameter int CNT_W   = 16,
   parameter int BUS_W   = 8,
   parameter bit TOP_SRC = 1'b1,
   localparam int HI_W   = CNT_W - BUS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic             upd_strobe,
   input  logic             buf_mode,
   input  logic [1:0]       pin_mode,
   input  logic             bus_we,
   input  logic [1:0]       bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   input  logic             irq_ack,
   output logic [HI_W-1:0]  tmp_byte,
   output logic [CNT_W-1:0] active_cmp,
   output logic             cmp_flag,
   output logic             irq,
   output logic             match_pulse,
   output logic             pin_out,
   output logic             pin_oe,
   output logic [CNT_W-1:0] top_value
);
   import tcmp_pkg::*;

   if (CNT_W != 2 * BUS_W) begin : g_bad_width
      $error("tcmp_channel: CNT_W must be twice BUS_W");
   end
   if (BUS_W < 2) begin : g_bad_bus
      $error("tcmp_channel: BUS_W must hold the control bits");
   end

   logic hit;
   logic ctl_we;

   assign ctl_we = bus_we && (bus_addr == ADDR_CTL);

   tcmp_regif #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regif (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .buf_mode   (buf_mode),
      .upd_strobe (upd_strobe),
      .tmp_byte   (tmp_byte),
      .active_val (active_cmp)
   );

   tcmp_match #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_match (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .cnt         (cnt),
      .active_val  (active_cmp),
      .ctl_we      (ctl_we),
      .ctl_data    (bus_wdata),
      .irq_ack     (irq_ack),
      .hit         (hit),
      .match_pulse (match_pulse),
      .flag        (cmp_flag),
      .irq         (irq)
   );

   tcmp_pin u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .pin_mode (pin_mode),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe)
   );

   if (TOP_SRC) begin : g_top_src
      assign top_value = active_cmp;
   end else begin : g_top_max
      assign top_value = '1;
   end
endmodule

// File: rtl/tcmp_channel_chk.sv
module tcmp_channel_chk #(
   parameter int CNT_W = 16,
   parameter int BUS_W = 8,
   localparam int HI_W = CNT_W - BUS_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic             upd_strobe,
   input logic             buf_mode,
   input logic             bus_we,
   input logic [1:0]       bus_addr,
   input logic [BUS_W-1:0] bus_wdata,
   input logic             irq_ack,
   input logic [HI_W-1:0]  tmp_byte,
   input logic [CNT_W-1:0] active_cmp,
   input logic             cmp_flag,
   input logic             irq,
   input logic             match_pulse,
   input logic             pin_out
);
   logic eq_tick;
   assign eq_tick = tick && (cnt == active_cmp);

   p_flag_after_eq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eq_tick |=> cmp_flag);

   p_pulse_after_eq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eq_tick |=> match_pulse);

   p_no_pulse_without_eq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !eq_tick |=> !match_pulse);

   p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cmp_flag);

   p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !eq_tick) |=> !cmp_flag);

   p_immediate_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 2'd0 && !buf_mode)
      |=> active_cmp == {$past(tmp_byte), $past(bus_wdata)});

   p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_strobe && !(bus_we && bus_addr == 2'd0)) |=> $stable(active_cmp));

   p_pin_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !eq_tick |=> $stable(pin_out));
endmodule

bind tcmp_channel tcmp_channel_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .cnt         (cnt),
   .upd_strobe  (upd_strobe),
   .buf_mode    (buf_mode),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .irq_ack     (irq_ack),
   .tmp_byte    (tmp_byte),
   .active_cmp  (active_cmp),
   .cmp_flag    (cmp_flag),
   .irq         (irq),
   .match_pulse (match_pulse),
   .pin_out     (pin_out)
);

// File: tb/tcmp_channel_tb.sv
module tcmp_channel_tb;
   localparam int CNT_W = 16;
   localparam int BUS_W = 8;

   // {pin_mode[1:0], hit, expected pin}
   localparam logic [3:0] VEC [10] = '{
      4'b0111, 4'b0110, 4'b1100, 4'b1111, 4'b1001,
      4'b1010, 4'b0010, 4'b0100, 4'b0111, 4'b0011
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick = 1'b0;
   logic [CNT_W-1:0] cnt = '0;
   logic             upd_strobe = 1'b0;
   logic             buf_mode = 1'b0;
   logic [1:0]       pin_mode = 2'b00;
   logic             bus_we = 1'b0;
   logic [1:0]       bus_addr = 2'd0;
   logic [BUS_W-1:0] bus_wdata = '0;
   logic             irq_ack = 1'b0;

   logic [BUS_W-1:0] tmp_byte, a_tmp;
   logic [CNT_W-1:0] active_cmp, top_value, a_act, a_top;
   logic cmp_flag, irq, match_pulse, pin_out, pin_oe;
   logic a_flag, a_irq, a_mp, a_pin, a_oe;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tcmp_channel #(.CNT_W(CNT_W), .BUS_W(BUS_W), .TOP_SRC(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .upd_strobe(upd_strobe),
      .buf_mode(buf_mode), .pin_mode(pin_mode), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .irq_ack(irq_ack), .tmp_byte(tmp_byte),
      .active_cmp(active_cmp), .cmp_flag(cmp_flag), .irq(irq),
      .match_pulse(match_pulse), .pin_out(pin_out), .pin_oe(pin_oe),
      .top_value(top_value)
   );

   tcmp_channel #(.CNT_W(CNT_W), .BUS_W(BUS_W), .TOP_SRC(1'b0)) u_alt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .upd_strobe(upd_strobe),
      .buf_mode(buf_mode), .pin_mode(pin_mode), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .irq_ack(irq_ack), .tmp_byte(a_tmp),
      .active_cmp(a_act), .cmp_flag(a_flag), .irq(a_irq),
      .match_pulse(a_mp), .pin_out(a_pin), .pin_oe(a_oe),
      .top_value(a_top)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [BUS_W-1:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic hit_cycle(input logic [CNT_W-1:0] c);
      cnt = c; tick = 1'b1;
      @(negedge clk);
      tick = 1'b0; cnt = ~c;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      cnt = 16'hFFFF;
      repeat (2) @(negedge clk);
      // R1 reset state
      chk("R1 tmp", tmp_byte, 0);
      chk("R1 active", active_cmp, 0);
      chk("R1 flag", cmp_flag, 0);
      chk("R1 pin", {match_pulse, pin_out, irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 upper byte only to temporary
      wr(2'd1, 8'h12);
      chk("R2 tmp", tmp_byte, 8'h12);
      chk("R2 active", active_cmp, 0);
      // R3 immediate load
      wr(2'd0, 8'h34);
      chk("R3 active", active_cmp, 16'h1234);

      // R4 staged load
      buf_mode = 1'b1;
      wr(2'd1, 8'hAB);
      wr(2'd0, 8'hCD);
      chk("R4 held", active_cmp, 16'h1234);
      upd_strobe = 1'b1;
      @(negedge clk);
      upd_strobe = 1'b0;
      chk("R4 strobe", active_cmp, 16'hABCD);
      chk("R11 top", top_value, 16'hABCD);
      chk("R11 max", a_top, 16'hFFFF);

      // R5 no tick, no hit
      cnt = 16'hABCD;
      @(negedge clk);
      chk("R5 no tick", {match_pulse, cmp_flag}, 0);
      cnt = 16'h0000;
      // R5 R6 hit
      hit_cycle(16'hABCD);
      chk("R5 pulse", match_pulse, 1);
      chk("R6 flag", cmp_flag, 1);
      chk("R7 irq off", irq, 0);
      @(negedge clk);
      chk("R5 single", match_pulse, 0);
      chk("R6 sticky", cmp_flag, 1);

      // R9 write zero leaves flag, sets enable
      wr(2'd2, 8'h02);
      chk("R9 zero", cmp_flag, 1);
      chk("R7 irq on", irq, 1);
      wr(2'd2, 8'h03);
      chk("R9 clear", cmp_flag, 0);
      chk("R7 irq drop", irq, 0);

      // R8 acknowledge
      hit_cycle(16'hABCD);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      chk("R8 ack", cmp_flag, 0);
      irq_ack = 1'b1;
      hit_cycle(16'hABCD);
      irq_ack = 1'b0;
      chk("R8 set wins", cmp_flag, 1);

      // R10 pin action table
      for (int i = 0; i < 10; i++) begin
         pin_mode = VEC[i][3:2];
         if (VEC[i][1]) hit_cycle(16'hABCD);
         else hit_cycle(16'h5555);
         chk("R10 pin", pin_out, VEC[i][0]);
         chk("R10 oe", pin_oe, (VEC[i][3:2] != 2'b00));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule